// File: doc/BRIEF.md
# Target-Side In-Band Interrupt Arbiter

This block sits in a target on a two-wire bus whose clock is owned by an active controller. When a local interrupt request is raised, it waits until it has seen both lines high for a programmable number of system clocks. It then creates a START condition by pulling the data line low. Pulling the data line low for a START is the only thing a target may do without the controller's clock. From then on the controller supplies every clock edge, and the block sends its 7-bit address on those edges with open-drain drive, most significant bit first.

A '0' bit is driven low and a '1' bit is released, so the line acts as a wired-AND. A device that releases the line but samples it low has been outvoted by a lower address. It drops off the line for the rest of the header and pulses `lost`. If all seven bits go out without such a mismatch, the block pulses `won`. A device joining the bus late uses the same mechanism: it presents its reserved joining address on `own_addr`. If the controller ends the header with a STOP before the seventh bit, the attempt is abandoned. The request is then still pending, and the block tries again once the bus is idle.

Top module: `ibi_arbiter`

## Requirements
- R1: After reset, `sda_oe`, `won` and `lost` are all 0.
- R2: With `irq_req` high, the block raises `sda_oe` (a START) only after SDA and SCL have both been high for `idle_limit` consecutive clocks, and no later than two clocks after that. While either line is held low, it never starts.
- R3: While `irq_req` is low, `sda_oe` stays 0 however long the bus is idle.
- R4: Once the START is made, `sda_oe` changes only while SCL is low. It is constant over every clock in which SCL stays high.
- R5: After the first SCL fall following the START, address bits go out from bit 6 down to bit 0, one bit for each SCL low phase. A '0' bit is shown as `sda_oe`=1, and a '1' bit is shown as `sda_oe`=0.
- R6: If a bit sent as '1' is sampled as 0 at the SCL rising edge, `lost` pulses for exactly one clock. `sda_oe` then stays 0 for the remaining bits and until the next STOP. Hence the lower of two competing addresses wins (7'h10 beats 7'h14).
- R7: If all seven bits are sampled without a mismatch, `won` pulses for exactly one clock after the seventh SCL rise. `sda_oe` is released at the next SCL fall. `won` and `lost` never pulse together.
- R8: A STOP (SDA rising while SCL is high) before the seventh bit ends the attempt with no `won` or `lost` pulse and `sda_oe` at 0. If `irq_req` is still high, a new START follows once the bus is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Sampled data line level |
| scl_in | input | 1 | Sampled clock line level |
| irq_req | input | 1 | Pending interrupt or join request (level) |
| own_addr | input | ADDR_W | Address to present during arbitration |
| idle_limit | input | IDLE_W | Clocks of both lines high that count as an idle bus |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| won | output | 1 | One-clock pulse when arbitration is won |
| lost | output | 1 | One-clock pulse when arbitration is lost |

## Verification
The hardest case to reach is a STOP in the middle of the address. A STOP needs SDA to rise while SCL is high. Any SCL rise before that rise is also a sampling point where a low line would count as a loss. The bench therefore lets a '1' bit be sampled high, keeps SCL high, pulls SDA low and releases it. This produces a clean STOP with no false loss. A second arbitration with the request still held then confirms the retry. Losses are produced by a modelled competing target whose open-drain drive is wire-ANDed with the block's own.

// File: rtl/ibi_arbiter.sv
module ibi_arbiter #(
  parameter int ADDR_W = 7,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_in,
  input  logic              scl_in,
  input  logic              irq_req,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              sda_oe,
  output logic              won,
  output logic              lost
);
  localparam int IDX_W = $clog2(ADDR_W + 1);
  localparam logic [1:0] ST_WATCH = 2'd0, ST_START = 2'd1, ST_SHIFT = 2'd2, ST_HOLD = 2'd3;
  localparam logic [IDLE_W-1:0] CNT_MAX = '1;

  logic [1:0]        st;
  logic              sda_q, scl_q, drv;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_q;
  logic [IDLE_W-1:0] idle_cnt;

  wire scl_rise  = !scl_q && scl_in;
  wire scl_fall  = scl_q && !scl_in;
  wire stop_seen = scl_q && scl_in && !sda_q && sda_in;
  wire lines_hi  = sda_in && scl_in;
  wire idle_ok   = lines_hi && (idle_cnt >= idle_limit);

  assign sda_oe = drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
      idle_cnt <= '0;
    end else begin
      sda_q <= sda_in;
      scl_q <= scl_in;
      if (!lines_hi) idle_cnt <= '0;
      else if (idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_WATCH;
      drv <= 1'b0;
      idx <= '0;
      addr_q <= '0;
      won <= 1'b0;
      lost <= 1'b0;
    end else begin
      won <= 1'b0;
      lost <= 1'b0;
      case (st)
        ST_WATCH: begin
          if (irq_req && idle_ok) begin
            drv <= 1'b1;
            addr_q <= own_addr;
            st <= ST_START;
          end
        end
        ST_START: begin
          if (scl_fall) begin
            idx <= IDX_W'(ADDR_W - 1);
            drv <= ~addr_q[ADDR_W-1];
            st <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (stop_seen) begin
            drv <= 1'b0;
            st <= ST_WATCH;
          end else if (scl_rise) begin
            if (!drv && !sda_in) begin
              lost <= 1'b1;
              st <= ST_HOLD;
            end else if (idx == '0) begin
              won <= 1'b1;
              st <= ST_HOLD;
            end
          end else if (scl_fall) begin
            idx <= idx - 1'b1;
            drv <= ~addr_q[idx - 1'b1];
          end
        end
        default: begin
          if (scl_fall) drv <= 1'b0;
          if (stop_seen) begin
            drv <= 1'b0;
            st <= ST_WATCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ibi_arbiter_chk.sv
module ibi_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_in,
  input logic       scl_in,
  input logic       irq_req,
  input logic       sda_oe,
  input logic       won,
  input logic       lost,
  input logic [1:0] st
);
  assert_start_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(st) == 2'd0) |-> ($past(irq_req) && $past(sda_in) && $past(scl_in)));

  assert_oe_stable_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in) && $past(st) != 2'd0 && st != 2'd0) |-> $stable(sda_oe));

  assert_lost_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !lost);

  assert_lost_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !sda_oe);

  assert_won_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    won |=> !won);

  assert_no_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(won && lost));
endmodule

bind ibi_arbiter ibi_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in), .irq_req(irq_req),
  .sda_oe(sda_oe), .won(won), .lost(lost), .st(st)
);

// File: tb/ibi_arbiter_tb.sv
`timescale 1ns/1ps
module ibi_arbiter_tb;
  localparam int LIM = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, ctrl_low = 1'b0, comp_low = 1'b0, req = 1'b0;
  logic [6:0] addr = '0;
  logic [15:0] limit = 16'(LIM);
  logic sda_oe, won, lost;
  wire sda = ~(sda_oe | ctrl_low | comp_low);
  int checks = 0, errors = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  ibi_arbiter u_dut (.clk(clk), .rst_n(rst_n), .sda_in(sda), .scl_in(scl), .irq_req(req),
    .own_addr(addr), .idle_limit(limit), .sda_oe(sda_oe), .won(won), .lost(lost));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: 1 = won, 2 = lost
  always @(negedge clk) begin
    if (rst_n && (won || lost)) begin
      int got, e;
      got = won ? 1 : 2;
      if (won && lost) got = 3;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 0;
      chk(got == e, "R6/R7 outcome", got, e);
    end
  end

  task automatic run_arb(input logic [6:0] a, input bit comp_on, input logic [6:0] ca,
                         input int abort_b, input bit measure);
    bit alive, c_alive, line;
    int n;
    addr = a;
    req = 1'b1;
    if (measure) begin
      ctrl_low = 1'b1;
      wclk(LIM + 10);
      chk(sda_oe == 1'b0, "R2 busy bus", sda_oe, 0);
      ctrl_low = 1'b0;
    end
    n = 0;
    while (!sda_oe && n < 400) begin wclk(1); n++; end
    if (measure) chk(n >= LIM && n <= LIM + 2, "R2 idle delay", n, LIM);
    else chk(sda_oe == 1'b1, "R2 start", sda_oe, 1);
    wclk(4);
    scl = 1'b0;
    alive = 1;
    c_alive = comp_on;
    for (int b = 6; b >= 0; b--) begin
      wclk(2);
      comp_low = c_alive && !ca[b];
      wclk(2);
      if (alive) chk(sda_oe == !a[b], "R5 bit drive", sda_oe, !a[b]);
      else chk(sda_oe == 1'b0, "R6 released after loss", sda_oe, 0);
      line = !((alive && !a[b]) || (c_alive && !ca[b]));
      if (alive && a[b] && !line) begin alive = 0; exp_q.push_back(2); end
      else if (alive && b == 0) exp_q.push_back(1);
      if (c_alive && ca[b] && !line) c_alive = 0;
      scl = 1'b1;
      wclk(4);
      chk(sda_oe == (alive && !a[b] && abort_b != b && !(b == 0)) || (alive && !a[b]),
          "R4 hold while high", sda_oe, alive && !a[b]);
      if (abort_b == b) begin
        ctrl_low = 1'b1;
        wclk(3);
        ctrl_low = 1'b0;
        comp_low = 1'b0;
        wclk(3);
        chk(sda_oe == 1'b0, "R8 abort released", sda_oe, 0);
        chk(exp_q.size() == 0, "R8 no pulse", exp_q.size(), 0);
        return;
      end
      scl = 1'b0;
    end
    req = 1'b0;
    wclk(3);
    chk(sda_oe == 1'b0, "R7 release after header", sda_oe, 0);
    comp_low = 1'b0;
    ctrl_low = 1'b1;
    wclk(2);
    scl = 1'b1;
    wclk(2);
    ctrl_low = 1'b0;
    wclk(4);
    chk(sda_oe == 1'b0, "R6/R7 idle after stop", sda_oe, 0);
    chk(exp_q.size() == 0, "R6/R7 outcome seen", exp_q.size(), 0);
  endtask

  initial begin
    wclk(3);
    chk(sda_oe == 0 && won == 0 && lost == 0, "R1 reset", {sda_oe, won, lost}, 0);
    rst_n = 1'b1;
    wclk(100);
    chk(sda_oe == 1'b0, "R3 no request", sda_oe, 0);
    run_arb(7'h10, 0, 7'h00, -1, 1);
    run_arb(7'h10, 1, 7'h14, -1, 0);
    run_arb(7'h14, 1, 7'h10, -1, 0);
    run_arb(7'h7F, 1, 7'h00, -1, 0);
    run_arb(7'h00, 0, 7'h00, -1, 1);
    run_arb(7'h55, 1, 7'h55, -1, 0);
    run_arb(7'h2A, 0, 7'h00, 5, 0);
    run_arb(7'h2A, 0, 7'h00, -1, 1);
    wclk(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule